// File: doc/BRIEF.md
# Configurable Serial Transmitter with Character Queue

This block turns characters written into a small queue into asynchronous serial frames on a single TX line. Each frame is a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. Characters are 8 or 9 bits wide. The line rests high between frames. A 16-bit divisor and a speed-mode input set the bit timing. A request input sends a break, a long low stretch on the line. A clear-to-send input can hold back new frames.

Characters enter through a valid/ready stream port. A character is taken on a rising clock edge where `in_valid` and `in_ready` are both high. While `in_ready` is low the producer must hold `in_valid` and `in_data` steady, and nothing is taken. `in_ready` is low exactly when the queue is full. The configuration inputs are plain levels and must stay stable while a frame is on the line. A single `tx_irq` pulse reports one of three selectable events.

Top module: `serial_tx_engine`

## Requirements
- R1: After reset `tx` is 1, `fifo_empty` is 1, `fifo_full` is 0, `in_ready` is 1 and `tx_irq` is 0. `tx` stays 1 whenever no frame or break is in progress.
- R2: A frame starts with one low start bit, then sends the data bits least significant bit first, then its stop bits. With `cfg_fast`=0 every bit lasts (cfg_divisor+1)*16 clock cycles.
- R3: With `cfg_fast`=1 every bit lasts (cfg_divisor+1)*4 clock cycles.
- R4: With `cfg_wide`=1 each frame carries all 9 bits of `in_data` and no parity bit, whatever `cfg_parity` holds. With `cfg_wide`=0 only `in_data[7:0]` is sent.
- R5: With `cfg_wide`=0 and `cfg_parity`=01, one parity bit follows the data and makes the number of ones even. With `cfg_parity`=10 the parity bit makes that number odd. The codes 00 and 11 add no parity bit.
- R6: `cfg_two_stop`=0 ends a frame with one high stop bit. `cfg_two_stop`=1 ends it with two.
- R7: The queue holds 4 characters and sends them in write order. With 4 stored, `fifo_full` is 1 and `in_ready` is 0, and a character offered then is not taken.
- R8: With `cfg_flow_en`=1 no frame starts while `cts` is 0, and queued frames start once `cts` is 1. With `cfg_flow_en`=0, `cts` has no effect.
- R9: A one-cycle `brk_req` pulse makes the block hold `tx` low for 13 bit periods and then send one high stop bit. The break starts after any frame in progress. It takes priority over characters waiting in the queue.
- R10: `tx_irq` is a one-cycle pulse. `cfg_irq_sel` selects its event: 00 when a character leaves the queue, 01 when the queue becomes empty, 10 when the last stop bit of a character frame ends with the queue empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A character is offered on `in_data` |
| in_ready | output | 1 | The queue can take a character |
| in_data | input | 9 | Character; bit 8 is used only in 9-bit mode |
| fifo_full | output | 1 | The queue holds 4 characters |
| fifo_empty | output | 1 | The queue holds no character |
| cfg_divisor | input | 16 | Prescaler divisor; one tick every divisor+1 cycles |
| cfg_wide | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| cfg_parity | input | 2 | 01 even, 10 odd, other codes none |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_fast | input | 1 | 1 selects 4 ticks per bit, 0 selects 16 |
| cfg_flow_en | input | 1 | Gate frame starts on `cts` |
| cfg_irq_sel | input | 2 | Interrupt event select (see R10) |
| brk_req | input | 1 | Pulse that requests a break |
| cts | input | 1 | Clear to send, active high |
| tx | output | 1 | Serial output, idle high |
| tx_irq | output | 1 | Interrupt pulse |

## Verification
The bench writes characters while `cts` is blocked, so the queue fills. A design that counted its depth wrongly would drop the fifth offered character or send a frame it never acknowledged. In 9-bit mode with parity configured, the bench checks the line where a stray parity bit would land. A framer that kept parity in that mode would show a low bit where the stop bit should be. A break and a character arrive together to test break priority, so a design with the order reversed would show a data frame first. The bench also counts interrupt pulses at fixed points across two back-to-back frames. This separates the three interrupt events, which differ only in when they fire.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BRK
  } txst_e;

  typedef struct packed {
    logic       wide;
    logic [1:0] par;
    logic       two_stop;
    logic       fast;
    logic       flow_en;
    logic [1:0] irq_sel;
  } txcfg_t;

  localparam logic [1:0] PAR_EVEN  = 2'b01;
  localparam logic [1:0] PAR_ODD   = 2'b10;
  localparam logic [1:0] IRQ_SLOT  = 2'b00;
  localparam logic [1:0] IRQ_EMPTY = 2'b01;
  localparam logic [1:0] IRQ_DONE  = 2'b10;

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam bit POW2 = (DEPTH == (1 << AW));

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  generate
    if (POW2) begin : g_wrap_nat
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_nxt;
      if (do_pop)  rd_ptr <= rd_nxt;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  // R7: a store without a matching read grows the occupancy by one
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop) |=> (count == $past(count) + 1'b1));
  // R7: a push offered while full leaves the occupancy at DEPTH
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> full);
  // R7: the framer never reads an empty queue
  a_r7_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int DIV_W      = 16,
  parameter int TICKS_SLOW = 16,
  parameter int TICKS_FAST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  input  logic             fast,
  output logic             bit_end
);
  localparam int SUB_W = $clog2(TICKS_SLOW);

  logic [DIV_W-1:0] pre_cnt;
  logic [SUB_W-1:0] sub_cnt, sub_last;
  logic             tick;

  assign sub_last = fast ? SUB_W'(TICKS_FAST - 1) : SUB_W'(TICKS_SLOW - 1);
  assign tick     = run && (pre_cnt == divisor);
  assign bit_end  = tick && (sub_cnt == sub_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      sub_cnt <= '0;
    end else if (!run) begin
      pre_cnt <= '0;
      sub_cnt <= '0;
    end else if (tick) begin
      pre_cnt <= '0;
      sub_cnt <= (sub_cnt == sub_last) ? '0 : sub_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  // R2/R3: a bit lasts at least four cycles, so bit ends never touch
  a_r3_bit_end_gap: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |=> !bit_end);
  // R2: the tick counters sit at zero whenever the line is idle
  a_r2_idle_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pre_cnt == '0 && sub_cnt == '0));

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
#(
  parameter int DATA_W   = 9,
  parameter int BRK_BITS = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  txcfg_t            cfg,
  input  logic              cts,
  input  logic              brk_req,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] head,
  input  logic              bit_end,
  output logic              pop,
  output logic              run,
  output logic              tx,
  output logic              frame_done
);
  localparam int MAXB  = (BRK_BITS > DATA_W) ? BRK_BITS : DATA_W;
  localparam int CNT_W = $clog2(MAXB + 1);

  txst_e             state;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_idx, data_last;
  logic              par_bit, brk_pend, is_brk;
  logic              par_en, start_ok, stop_last;

  assign data_last = cfg.wide ? CNT_W'(DATA_W - 1) : CNT_W'(DATA_W - 2);
  assign par_en    = !cfg.wide && (cfg.par == PAR_EVEN || cfg.par == PAR_ODD);
  assign start_ok  = !fifo_empty && (!cfg.flow_en || cts);
  assign pop       = (state == ST_IDLE) && !brk_pend && start_ok;
  assign run       = (state != ST_IDLE);
  assign stop_last = (is_brk || !cfg.two_stop) ? 1'b1 : (bit_idx == CNT_W'(1));
  assign frame_done = (state == ST_STOP) && bit_end && stop_last && !is_brk;

  always_comb begin
    unique case (state)
      ST_START: tx = 1'b0;
      ST_DATA:  tx = shreg[0];
      ST_PAR:   tx = par_bit;
      ST_BRK:   tx = 1'b0;
      default:  tx = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      bit_idx  <= '0;
      par_bit  <= 1'b0;
      brk_pend <= 1'b0;
      is_brk   <= 1'b0;
    end else begin
      if (brk_req) brk_pend <= 1'b1;
      unique case (state)
        ST_IDLE: begin
          bit_idx <= '0;
          if (brk_pend) begin
            brk_pend <= brk_req;
            is_brk   <= 1'b1;
            state    <= ST_BRK;
          end else if (start_ok) begin
            shreg   <= head;
            par_bit <= (cfg.par == PAR_EVEN) ? ^head[DATA_W-2:0] : ~^head[DATA_W-2:0];
            is_brk  <= 1'b0;
            state   <= ST_START;
          end
        end
        ST_START: if (bit_end) state <= ST_DATA;
        ST_DATA: if (bit_end) begin
          shreg <= shreg >> 1;
          if (bit_idx == data_last) begin
            bit_idx <= '0;
            state   <= par_en ? ST_PAR : ST_STOP;
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end
        ST_PAR: if (bit_end) state <= ST_STOP;
        ST_STOP: if (bit_end) begin
          if (stop_last) begin
            bit_idx <= '0;
            state   <= ST_IDLE;
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end
        ST_BRK: if (bit_end) begin
          if (bit_idx == CNT_W'(BRK_BITS - 1)) begin
            bit_idx <= '0;
            state   <= ST_STOP;
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: nothing on the line drives it low while no frame runs
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> tx);
  // R8: with gating on, a character leaves the queue only under cts
  a_r8_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cfg.flow_en) |-> cts);
  // R4: 9-bit frames never reach the parity state
  a_r4_no_par_wide: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.wide |-> (state != ST_PAR));
  // R9: the last break bit hands over to a high stop bit
  a_r9_break_to_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BRK && bit_end && bit_idx == CNT_W'(BRK_BITS - 1)) |=> (state == ST_STOP && tx));
  // R9: a pending break is served before any waiting character
  a_r9_break_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && brk_pend) |=> (state == ST_BRK));

endmodule

// File: rtl/serial_tx_engine.sv
module serial_tx_engine
  import sertx_pkg::*;
#(
  parameter int DATA_W   = 9,
  parameter int DEPTH    = 4,
  parameter int DIV_W    = 16,
  parameter int BRK_BITS = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              fifo_full,
  output logic              fifo_empty,
  input  logic [DIV_W-1:0]  cfg_divisor,
  input  logic              cfg_wide,
  input  logic [1:0]        cfg_parity,
  input  logic              cfg_two_stop,
  input  logic              cfg_fast,
  input  logic              cfg_flow_en,
  input  logic [1:0]        cfg_irq_sel,
  input  logic              brk_req,
  input  logic              cts,
  output logic              tx,
  output logic              tx_irq
);
  txcfg_t            cfg;
  logic [DATA_W-1:0] head;
  logic              pop, run, bit_end, frame_done;
  logic              empty_q, irq_ev;

  assign cfg = '{wide: cfg_wide, par: cfg_parity, two_stop: cfg_two_stop,
                 fast: cfg_fast, flow_en: cfg_flow_en, irq_sel: cfg_irq_sel};
  assign in_ready = !fifo_full;

  sertx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(in_valid), .wdata(in_data), .pop(pop),
    .head(head), .full(fifo_full), .empty(fifo_empty)
  );

  sertx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(run), .divisor(cfg_divisor),
    .fast(cfg_fast), .bit_end(bit_end)
  );

  sertx_framer #(.DATA_W(DATA_W), .BRK_BITS(BRK_BITS)) u_framer (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .cts(cts), .brk_req(brk_req),
    .fifo_empty(fifo_empty), .head(head), .bit_end(bit_end), .pop(pop),
    .run(run), .tx(tx), .frame_done(frame_done)
  );

  always_comb begin
    unique case (cfg.irq_sel)
      IRQ_SLOT:  irq_ev = pop;
      IRQ_EMPTY: irq_ev = fifo_empty && !empty_q;
      IRQ_DONE:  irq_ev = frame_done && fifo_empty;
      default:   irq_ev = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      tx_irq  <= 1'b0;
    end else begin
      empty_q <= fifo_empty;
      tx_irq  <= irq_ev;
    end
  end

  // R10: the interrupt is a single-cycle pulse
  a_r10_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);
  // R10: the empty-event pulse follows the queue draining
  a_r10_empty_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && cfg_irq_sel == IRQ_EMPTY && $stable(cfg_irq_sel)) |-> $past(fifo_empty));

endmodule

// File: tb/serial_tx_engine_tb_top.sv
module serial_tx_engine_tb_top;
  typedef struct {
    bit       brk;
    bit [8:0] d;
    int       nb;
    bit       has_par;
    bit       pbit;
    int       nstop;
  } exp_t;

  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, brk_req = 0, cts = 1;
  logic [8:0]  in_data = '0;
  logic [15:0] cfg_divisor = 16'd1;
  logic        cfg_wide = 0, cfg_two_stop = 0, cfg_fast = 0, cfg_flow_en = 0;
  logic [1:0]  cfg_parity = 2'b00, cfg_irq_sel = 2'b00;
  logic        in_ready, fifo_full, fifo_empty, tx, tx_irq;

  int   n_chk = 0, n_bad = 0, P = 32, irq_cnt = 0, fall_cnt = 0;
  bit   done = 0;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  serial_tx_engine dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .cfg_divisor(cfg_divisor), .cfg_wide(cfg_wide), .cfg_parity(cfg_parity),
    .cfg_two_stop(cfg_two_stop), .cfg_fast(cfg_fast), .cfg_flow_en(cfg_flow_en),
    .cfg_irq_sel(cfg_irq_sel), .brk_req(brk_req), .cts(cts), .tx(tx), .tx_irq(tx_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic exp_t mk(input bit [8:0] d);
    exp_t e;
    e.brk     = 0;
    e.d       = cfg_wide ? d : {1'b0, d[7:0]};
    e.nb      = cfg_wide ? 9 : 8;
    e.has_par = !cfg_wide && (cfg_parity == 2'b01 || cfg_parity == 2'b10);
    e.pbit    = (cfg_parity == 2'b01) ? ^d[7:0] : ~^d[7:0];
    e.nstop   = cfg_two_stop ? 2 : 1;
    return e;
  endfunction

  // caller stands at a falling clock edge
  task automatic push(input bit [8:0] d);
    in_valid = 1; in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic send(input bit [8:0] d);
    exp_q.push_back(mk(d));
    push(d);
  endtask

  task automatic quiet();
    wait (exp_q.size() == 0);
    repeat (16 * P) @(negedge clk);
  endtask

  // counters of interrupt pulses and line falls
  always @(negedge clk) if (rst_n && tx_irq) irq_cnt++;
  always @(negedge tx) if (rst_n) fall_cnt++;

  // monitor: decodes frames and compares them with the scoreboard
  initial begin
    exp_t e;
    wait (rst_n);
    forever begin
      @(negedge tx);
      if (exp_q.size() == 0) begin
        chk(0, "R7 unexpected frame", 1, 0);
        repeat (16 * P) @(negedge clk);
      end else begin
        e = exp_q.pop_front();
        repeat (P / 2) @(negedge clk);
        chk(tx == 0, "R2 start bit", tx, 0);
        if (e.brk) begin
          for (int i = 1; i < 13; i++) begin
            repeat (P) @(negedge clk);
            chk(tx == 0, "R9 break low", tx, 0);
          end
          repeat (P) @(negedge clk);
          chk(tx == 1, "R9 break stop", tx, 1);
        end else begin
          for (int i = 0; i < e.nb; i++) begin
            repeat (P) @(negedge clk);
            chk(tx == e.d[i], (e.nb == 9) ? "R4 data bit" : "R2 data bit", tx, e.d[i]);
          end
          if (e.has_par) begin
            repeat (P) @(negedge clk);
            chk(tx == e.pbit, "R5 parity bit", tx, e.pbit);
          end
          for (int i = 0; i < e.nstop; i++) begin
            repeat (P) @(negedge clk);
            chk(tx == 1, "R6 stop bit", tx, 1);
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    report();
  end

  initial begin
    int b0, b1, f0;
    int exp5[3], exp15[3], exp25[3];
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(tx == 1, "R1 tx idle", tx, 1);
    chk(fifo_empty == 1, "R1 empty", fifo_empty, 1);
    chk(fifo_full == 0, "R1 full", fifo_full, 0);
    chk(in_ready == 1, "R1 ready", in_ready, 1);
    chk(tx_irq == 0, "R1 irq", tx_irq, 0);

    // R2 plain 8N1 frames
    send(9'h0A5); send(9'h03C);
    quiet();
    // R5 even then odd parity
    cfg_parity = 2'b01;
    send(9'h007); send(9'h080);
    quiet();
    cfg_parity = 2'b10;
    send(9'h007);
    quiet();
    cfg_parity = 2'b11;
    send(9'h0F0);
    quiet();
    // R6 two stop bits
    cfg_parity = 2'b00; cfg_two_stop = 1;
    send(9'h05A);
    quiet();
    cfg_two_stop = 0;
    // R4 9-bit mode, parity configured but unused
    cfg_wide = 1; cfg_parity = 2'b01;
    send(9'h1A5); send(9'h0F3);
    quiet();
    cfg_wide = 0; cfg_parity = 2'b00;
    send(9'h1C3); // R4 bit 8 dropped in 8-bit mode
    quiet();
    // R3 fast mode with divisor 3
    cfg_fast = 1; cfg_divisor = 16'd3; P = 16;
    send(9'h0C3); send(9'h001);
    quiet();
    cfg_fast = 0; cfg_divisor = 16'd1; P = 32;

    // R7 / R8 queue fill under blocked cts
    cfg_flow_en = 1; cts = 0;
    f0 = fall_cnt;
    send(9'h011); send(9'h022); send(9'h033); send(9'h044);
    repeat (4) @(negedge clk);
    chk(fifo_full == 1, "R7 full at 4", fifo_full, 1);
    chk(in_ready == 0, "R7 ready low at 4", in_ready, 0);
    in_valid = 1; in_data = 9'h055;
    repeat (20) @(negedge clk);
    chk(in_ready == 0, "R7 fifth not taken", in_ready, 0);
    in_valid = 0;
    repeat (100) @(negedge clk);
    chk(fall_cnt == f0, "R8 no frame without cts", fall_cnt - f0, 0);
    cts = 1;
    quiet();
    chk(fifo_empty == 1, "R7 drained", fifo_empty, 1);
    // R8 cts ignored with gating off
    cfg_flow_en = 0; cts = 0;
    send(9'h066);
    quiet();
    cts = 1;

    // R9 break and character arrive together; break goes first
    begin
      exp_t eb;
      eb = mk(9'h077); eb.brk = 1;
      exp_q.push_back(eb);
      exp_q.push_back(mk(9'h077));
      in_valid = 1; in_data = 9'h077; brk_req = 1;
      @(negedge clk);
      in_valid = 0; brk_req = 0;
    end
    quiet();

    // R10 interrupt selections across two back-to-back frames
    exp5  = '{1, 0, 0};
    exp15 = '{2, 1, 0};
    exp25 = '{2, 1, 1};
    for (int s = 0; s < 3; s++) begin
      cfg_irq_sel = 2'(s);
      repeat (2) @(negedge clk);
      b0 = irq_cnt;
      send(9'h0AA); send(9'h055);
      repeat (5 * P) @(negedge clk);
      b1 = irq_cnt - b0;
      chk(b1 == exp5[s], "R10 irq count early", b1, exp5[s]);
      repeat (10 * P) @(negedge clk);
      b1 = irq_cnt - b0;
      chk(b1 == exp15[s], "R10 irq count mid", b1, exp15[s]);
      repeat (10 * P) @(negedge clk);
      b1 = irq_cnt - b0;
      chk(b1 == exp25[s], "R10 irq count end", b1, exp25[s]);
      quiet();
    end

    chk(exp_q.size() == 0, "R2 all frames seen", exp_q.size(), 0);
    chk(tx == 1, "R1 idle at end", tx, 1);
    report();
  end
endmodule